// File: doc/BRIEF.md
# Configurable NaN Classifier and Quieter

This unit inspects one floating-point value in half, bfloat16, single or double layout and says whether it is a NaN at all, and if so whether it is quiet or signaling. It also returns a quieted copy of the value and the default NaN pattern for the selected layout. The layout is picked per value by a 2-bit select. Narrow values sit right-justified on a 64-bit bus.

Three mode inputs fix the NaN rules at run time. The first sets the polarity of the top fraction bit, which is the bit that separates the two NaN kinds. The second switches signaling NaNs off completely. The third chooses among four default-NaN patterns. The logic is purely combinational. An optional output register, on by default, adds one cycle of latency so the unit can sit inside a pipelined floating-point front end.

Top module: `nan_sift`

## Requirements
- R1: `fmt_sel` picks the layout as sign/exponent/fraction widths: 0 = half (1/5/10), 1 = bfloat16 (1/8/7), 2 = single (1/8/23), 3 = double (1/11/52). The value occupies `val_in` bits [W-1:0], where W is the total width of the layout. Bits above W are ignored, and `quiet_out` and `dflt_nan` drive 0 there.
- R2: A value is a NaN (`is_nan`=1) exactly when its exponent field is all ones and its fraction is nonzero. Infinities, zeros and normal numbers give all three flags 0.
- R3: With `snan_inv`=0 and `snan_off`=0, a NaN whose top fraction bit is 0 is signaling and one whose top fraction bit is 1 is quiet. For single precision this means a value is a quiet NaN when its low 32 bits shifted left by one are at least 0xFF800000 as an unsigned number.
- R4: With `snan_inv`=1 and `snan_off`=0, a NaN whose top fraction bit is 1 is signaling. A NaN whose top fraction bit is 0 (so some lower fraction bit is set) is quiet.
- R5: With `snan_off`=1, `is_snan` is always 0 and every NaN is reported quiet, whatever the polarity.
- R6: For a signaling NaN, `quiet_out` sets the top fraction bit when `snan_inv`=0. When `snan_inv`=1 it clears the top fraction bit and sets the bit below it. Sign, exponent and the other fraction bits are kept.
- R7: When the value is not a signaling NaN, including every value while `snan_off`=1, `quiet_out` equals the value with the bits above W cleared.
- R8: With `dn_style`=0, `dflt_nan` has sign 0 and an all-ones exponent. Its fraction is only the top bit when `snan_inv`=0, and every bit except the top one when `snan_inv`=1.
- R9: With `dn_style`=1, `dflt_nan` has sign 0, an all-ones exponent and an all-ones fraction.
- R10: With `dn_style`=2, `dflt_nan` has sign 1, an all-ones exponent and only the top fraction bit set.
- R11: With `dn_style`=3, `dflt_nan` has sign 0, an all-ones exponent and only the second-highest fraction bit set.
- R12: With `REG_OUT`=1, outputs reflect the inputs of the previous rising clock edge. While `rst_n` is low, all outputs are 0.
- R13: `is_nan` equals `is_qnan` OR `is_snan`, and `is_qnan` and `is_snan` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | Layout select: half, bfloat16, single, double |
| snan_inv | input | 1 | 1 = a set top fraction bit marks a signaling NaN |
| snan_off | input | 1 | 1 = treat every NaN as quiet |
| dn_style | input | 2 | Default-NaN pattern select |
| val_in | input | 64 | Value, right-justified |
| is_nan | output | 1 | Value is any NaN |
| is_qnan | output | 1 | Value is a quiet NaN |
| is_snan | output | 1 | Value is a signaling NaN |
| quiet_out | output | 64 | Quieted value, or pass-through |
| dflt_nan | output | 64 | Default NaN for the selected layout and mode |

## Verification
Every layout is swept under both polarities, with signaling on and off, and under all four default-NaN styles.

Each sweep uses seven values:
- An infinity and a negative zero show that an all-ones exponent alone, or a sign bit alone, is not read as a NaN.
- A normal number checks pass-through.
- Three NaN shapes separate the two polarities: top bit set with a low bit set, top bit clear with a low bit set, and top bit set with nothing below it. The last one is an infinity-adjacent shape that is signaling only under the inverted rule.
- A negative NaN checks that the sign survives quieting.

Junk is placed above the layout width on every value to prove those bits are ignored.

// File: rtl/nan_sift_pkg.sv
package nan_sift_pkg;

  localparam int DATA_W  = 64;
  localparam int NUM_FMT = 4;

  typedef enum logic [1:0] {
    FMT_HALF   = 2'd0,
    FMT_BF16   = 2'd1,
    FMT_SINGLE = 2'd2,
    FMT_DOUBLE = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    DN_POLARITY = 2'd0,
    DN_ALL_ONES = 2'd1,
    DN_NEG_TOP  = 2'd2,
    DN_SECOND   = 2'd3
  } dn_style_e;

  typedef struct packed {
    logic              any_nan;
    logic              q_nan;
    logic              s_nan;
    logic [DATA_W-1:0] quieted;
    logic [DATA_W-1:0] dflt;
  } nan_result_t;

  function automatic int fmt_exp_w(int f);
    case (f)
      0:       return 5;
      1:       return 8;
      2:       return 8;
      default: return 11;
    endcase
  endfunction

  function automatic int fmt_frac_w(int f);
    case (f)
      0:       return 10;
      1:       return 7;
      2:       return 23;
      default: return 52;
    endcase
  endfunction

endpackage

// File: rtl/nan_classify.sv
module nan_classify #(
  parameter int EW = 8,
  parameter int FW = 23,
  localparam int W = 1 + EW + FW
) (
  input  logic [W-1:0] val,
  input  logic         snan_inv,
  input  logic         snan_off,
  output logic         any_nan,
  output logic         q_nan,
  output logic         s_nan
);

  logic exp_full;
  logic frac_nz;
  logic sig_state;

  always_comb begin
    exp_full  = &val[W-2:FW];
    frac_nz   = |val[FW-1:0];
    // top fraction bit matches the polarity's signaling value
    sig_state = (val[FW-1] == snan_inv);
    any_nan   = exp_full & frac_nz;
    s_nan     = any_nan & sig_state & ~snan_off;
    q_nan     = any_nan & ~s_nan;
  end

endmodule

// File: rtl/nan_quieten.sv
module nan_quieten #(
  parameter int EW = 8,
  parameter int FW = 23,
  localparam int W = 1 + EW + FW
) (
  input  logic [W-1:0] val,
  input  logic         s_nan,
  input  logic         snan_inv,
  output logic [W-1:0] quieted
);

  always_comb begin
    quieted = val;
    if (s_nan) begin
      if (snan_inv) begin
        quieted[FW-1] = 1'b0;
        quieted[FW-2] = 1'b1;
      end else begin
        quieted[FW-1] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/nan_default_gen.sv
module nan_default_gen
  import nan_sift_pkg::*;
#(
  parameter int EW = 8,
  parameter int FW = 23,
  localparam int W = 1 + EW + FW
) (
  input  logic         snan_inv,
  input  logic [1:0]   dn_style,
  output logic [W-1:0] dflt
);

  logic          sgn;
  logic [FW-1:0] frac;

  always_comb begin
    sgn  = 1'b0;
    frac = '0;
    case (dn_style_e'(dn_style))
      DN_POLARITY: begin
        if (snan_inv) frac = {1'b0, {(FW-1){1'b1}}};
        else          frac[FW-1] = 1'b1;
      end
      DN_ALL_ONES: frac = '1;
      DN_NEG_TOP: begin
        sgn        = 1'b1;
        frac[FW-1] = 1'b1;
      end
      default: frac[FW-2] = 1'b1;
    endcase
    dflt = {sgn, {EW{1'b1}}, frac};
  end

endmodule

// File: rtl/nan_sift.sv
module nan_sift
  import nan_sift_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fmt_sel,
  input  logic              snan_inv,
  input  logic              snan_off,
  input  logic [1:0]        dn_style,
  input  logic [DATA_W-1:0] val_in,
  output logic              is_nan,
  output logic              is_qnan,
  output logic              is_snan,
  output logic [DATA_W-1:0] quiet_out,
  output logic [DATA_W-1:0] dflt_nan
);

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_lane
    localparam int EW = fmt_exp_w(g);
    localparam int FW = fmt_frac_w(g);
    localparam int W  = 1 + EW + FW;

    logic              any_nan, q_nan, s_nan;
    logic [W-1:0]      q_w, d_w;
    logic [DATA_W-1:0] q64, d64;

    nan_classify #(.EW(EW), .FW(FW)) u_cls (
      .val      (val_in[W-1:0]),
      .snan_inv (snan_inv),
      .snan_off (snan_off),
      .any_nan  (any_nan),
      .q_nan    (q_nan),
      .s_nan    (s_nan)
    );

    nan_quieten #(.EW(EW), .FW(FW)) u_qt (
      .val      (val_in[W-1:0]),
      .s_nan    (s_nan),
      .snan_inv (snan_inv),
      .quieted  (q_w)
    );

    nan_default_gen #(.EW(EW), .FW(FW)) u_dn (
      .snan_inv (snan_inv),
      .dn_style (dn_style),
      .dflt     (d_w)
    );

    always_comb begin
      q64        = '0;
      d64        = '0;
      q64[W-1:0] = q_w;
      d64[W-1:0] = d_w;
    end
  end

  nan_result_t res_nx;
  nan_result_t res_q;

  always_comb begin
    case (fmt_e'(fmt_sel))
      FMT_HALF:   res_nx = '{g_lane[0].any_nan, g_lane[0].q_nan, g_lane[0].s_nan,
                             g_lane[0].q64, g_lane[0].d64};
      FMT_BF16:   res_nx = '{g_lane[1].any_nan, g_lane[1].q_nan, g_lane[1].s_nan,
                             g_lane[1].q64, g_lane[1].d64};
      FMT_SINGLE: res_nx = '{g_lane[2].any_nan, g_lane[2].q_nan, g_lane[2].s_nan,
                             g_lane[2].q64, g_lane[2].d64};
      default:    res_nx = '{g_lane[3].any_nan, g_lane[3].q_nan, g_lane[3].s_nan,
                             g_lane[3].q64, g_lane[3].d64};
    endcase
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_q <= '0;
      else        res_q <= res_nx;
    end
  end else begin : g_comb
    assign res_q = res_nx;
  end

  assign is_nan    = res_q.any_nan;
  assign is_qnan   = res_q.q_nan;
  assign is_snan   = res_q.s_nan;
  assign quiet_out = res_q.quieted;
  assign dflt_nan  = res_q.dflt;

endmodule

// File: rtl/nan_sift_chk.sv
module nan_sift_chk
  import nan_sift_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        fmt_sel,
  input logic              snan_inv,
  input logic              snan_off,
  input logic [DATA_W-1:0] val_in,
  input logic              is_nan,
  input logic              is_qnan,
  input logic              is_snan,
  input logic [DATA_W-1:0] quiet_out,
  input logic [DATA_W-1:0] dflt_nan
);

  function automatic logic [DATA_W-1:0] width_mask(logic [1:0] f);
    int w;
    w = 1 + fmt_exp_w(int'(f)) + fmt_frac_w(int'(f));
    if (w >= DATA_W) return '1;
    return (64'd1 << w) - 64'd1;
  endfunction

  function automatic logic [DATA_W-1:0] exp_mask(logic [1:0] f);
    int fw;
    fw = fmt_frac_w(int'(f));
    return ((64'd1 << fmt_exp_w(int'(f))) - 64'd1) << fw;
  endfunction

  function automatic logic [DATA_W-1:0] frac_mask(logic [1:0] f);
    return (64'd1 << fmt_frac_w(int'(f))) - 64'd1;
  endfunction

  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  // R13: flag consistency
  a_r13_flags_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> ((is_nan == (is_qnan | is_snan)) && !(is_qnan && is_snan)));

  if (REG_OUT) begin : g_seq
    // R5: signaling disabled never yields a signaling flag
    a_r5_off_blocks_snan: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(snan_off)) |-> !is_snan);

    // R7: non-signaling values pass through masked
    a_r7_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && !is_snan) |-> (quiet_out == ($past(val_in) & width_mask($past(fmt_sel)))));

    // R6: quieted value has the top fraction bit in its quiet state
    a_r6_quieted_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && is_snan) |->
        (quiet_out[fmt_frac_w(int'($past(fmt_sel))) - 1] == !$past(snan_inv)));

    // R8: default NaN always has a full exponent and nonzero fraction
    a_r8_dflt_is_nan: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> (((dflt_nan & exp_mask($past(fmt_sel))) == exp_mask($past(fmt_sel)))
                  && ((dflt_nan & frac_mask($past(fmt_sel))) != '0)));
  end

endmodule

bind nan_sift nan_sift_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fmt_sel   (fmt_sel),
  .snan_inv  (snan_inv),
  .snan_off  (snan_off),
  .val_in    (val_in),
  .is_nan    (is_nan),
  .is_qnan   (is_qnan),
  .is_snan   (is_snan),
  .quiet_out (quiet_out),
  .dflt_nan  (dflt_nan)
);

// File: tb/nan_sift_tb.sv
module nan_sift_tb;

  logic        clk;
  logic        rst_n;
  logic [1:0]  fmt_sel;
  logic        snan_inv;
  logic        snan_off;
  logic [1:0]  dn_style;
  logic [63:0] val_in;
  logic        is_nan, is_qnan, is_snan;
  logic [63:0] quiet_out, dflt_nan;

  int tests_run = 0;
  int tests_fail = 0;
  bit done = 1'b0;

  nan_sift u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt_sel   (fmt_sel),
    .snan_inv  (snan_inv),
    .snan_off  (snan_off),
    .dn_style  (dn_style),
    .val_in    (val_in),
    .is_nan    (is_nan),
    .is_qnan   (is_qnan),
    .is_snan   (is_snan),
    .quiet_out (quiet_out),
    .dflt_nan  (dflt_nan)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ew_of(int f);
    case (f) 0: return 5; 1: return 8; 2: return 8; default: return 11; endcase
  endfunction
  function automatic int fw_of(int f);
    case (f) 0: return 10; 1: return 7; 2: return 23; default: return 52; endcase
  endfunction

  function automatic logic [63:0] ones(int n);
    if (n >= 64) return '1;
    return (64'd1 << n) - 64'd1;
  endfunction

  function automatic logic [63:0] pattern(int f, int p);
    int ew, fw;
    logic [63:0] e_all, top, v;
    ew = ew_of(f); fw = fw_of(f);
    e_all = ones(ew) << fw;
    top   = 64'd1 << (fw - 1);
    case (p)
      0: v = e_all;                                        // +infinity
      1: v = 64'd1 << (ew + fw);                           // -zero
      2: v = ones(ew - 1) << fw;                           // 1.0
      3: v = e_all | top | 64'd1;                          // top set, low set
      4: v = e_all | 64'd1;                                // top clear, low set
      5: v = e_all | top;                                  // top only
      default: v = (64'd1 << (ew + fw)) | e_all | ones(fw - 1); // negative, top clear
    endcase
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests_fail++;
      $display("FAIL R12 watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fmt_sel = '0; snan_inv = 0; snan_off = 0; dn_style = '0; val_in = '0;
    repeat (3) @(negedge clk);
    check("R12 reset flags", {61'd0, is_nan, is_qnan, is_snan}, 64'd0);
    check("R12 reset quiet", quiet_out, 64'd0);
    check("R12 reset dflt", dflt_nan, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // latency: a NaN driven now must not show before the next rising edge
    fmt_sel = 2'd2; val_in = 64'h7FC0_0001;
    #1;
    check("R12 latency before edge", {63'd0, is_nan}, 64'd0);
    @(negedge clk);
    check("R12 latency after edge", {63'd0, is_nan}, 64'd1);

    for (int f = 0; f < 4; f++)
      for (int pol = 0; pol < 2; pol++)
        for (int off = 0; off < 2; off++)
          for (int st = 0; st < 4; st++)
            for (int p = 0; p < 7; p++) begin
              int ew, fw, w;
              logic [63:0] v, junk, e_all, frac, ex_q, ex_d;
              logic nan_e, sig_e, q_e, top;
              string tag;
              ew = ew_of(f); fw = fw_of(f); w = 1 + ew + fw;
              v = pattern(f, p);
              junk = (w < 64) ? (64'hA5C3_96F0_5A3C_690F & ~ones(w)) : 64'd0;
              fmt_sel = 2'(f); snan_inv = pol[0]; snan_off = off[0];
              dn_style = 2'(st); val_in = v | junk;
              @(negedge clk);
              e_all = ones(ew) << fw;
              frac  = v & ones(fw);
              top   = v[fw-1];
              nan_e = ((v & e_all) == e_all) && (frac != 0);
              sig_e = nan_e && !off[0] && (top == pol[0]);
              q_e   = nan_e && !sig_e;
              if (!nan_e)     tag = "R2";
              else if (off[0]) tag = "R5";
              else if (pol[0]) tag = "R4";
              else            tag = "R3";
              check($sformatf("R13 %s flags f=%0d p=%0d pol=%0d off=%0d", tag, f, p, pol, off),
                    {61'd0, is_nan, is_qnan, is_snan}, {61'd0, nan_e, q_e, sig_e});
              if (sig_e) begin
                if (pol[0]) ex_q = (v & ~(64'd1 << (fw - 1))) | (64'd1 << (fw - 2));
                else        ex_q = v | (64'd1 << (fw - 1));
                check($sformatf("R1 R6 quiet f=%0d p=%0d pol=%0d", f, p, pol), quiet_out, ex_q);
              end else begin
                check($sformatf("R1 R7 pass f=%0d p=%0d pol=%0d off=%0d", f, p, pol, off),
                      quiet_out, v);
              end
              ex_d = e_all;
              case (st)
                0: begin
                  ex_d = ex_d | (pol[0] ? ones(fw - 1) : (64'd1 << (fw - 1)));
                  tag = "R8";
                end
                1: begin ex_d = ex_d | ones(fw); tag = "R9"; end
                2: begin ex_d = ex_d | (64'd1 << (fw - 1)) | (64'd1 << (w - 1)); tag = "R10"; end
                default: begin ex_d = ex_d | (64'd1 << (fw - 2)); tag = "R11"; end
              endcase
              if (p == 0)
                check($sformatf("R1 %s dflt f=%0d pol=%0d", tag, f, pol), dflt_nan, ex_d);
              if (f == 2 && pol == 0 && off == 0 && st == 0) begin
                logic [31:0] sh;
                sh = {v[30:0], 1'b0};
                check($sformatf("R3 single shift rule p=%0d", p), {63'd0, is_qnan},
                      {63'd0, (sh >= 32'hFF80_0000)});
              end
            end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
    $finish;
  end

endmodule